// File: doc/BRIEF.md
# Target Command and Address Handoff

This block sits between the bus-facing half of a PCI target and the local application. When the bus side hands it a new target operation, it lowers an active-low request toward the application. It then presents the bus command on a dedicated command bus. The one or two address words go out on a shared data bus, with the FIFO select at 1. The application pulls each address word with an active-low address enable. A last-cycle marker flags the final word. A burst flag and a dual-address flag ride beside the address on a two-bit flag bus.

Once the final address word has been taken, the request drops and the read-data phase opens. The application writes read words back with an active-low enable. A word is accepted only while the downstream read FIFO has room. Each accepted word goes out as a push toward the FIFO, tagged with a rotating four-lane position. The word that carries the active-low read last-cycle marker ends the operation.

Top module: `tgt_addr_handoff`

## Requirements
- R1: While reset is asserted, and on its release: tgt_req_n=1, op_ready=1, fifo_sel=0, addr_last_n=1, app_flags=0, app_data=0, phase_cnt=0, rd_full_n=0, push=0.
- R2: When op_valid is high in a cycle with op_ready high, the operation is captured at that edge. From the next cycle, tgt_req_n=0 and op_ready=0.
- R3: While tgt_req_n=0: fifo_sel=1, cmd_out equals the captured command, app_flags[1] is the burst flag and app_flags[0] is the dual-address flag. Otherwise fifo_sel=0 and app_flags=0.
- R4: Address words move one per rising edge at which addr_en_n=0. Word 0 (op_addr_lo) is shown first and holds until taken. For a dual-address operation, word 1 (op_addr_hi) follows. phase_cnt shows the word index (0, then 1).
- R5: addr_last_n is 0 exactly while the final address word is shown. That is word 0 for a single-address operation and word 1 for a dual-address operation.
- R6: The edge that takes the final address word ends the address phase. From the next cycle tgt_req_n=1, and rd_full_n equals the inverse of sto_full.
- R7: In the read phase, a word is accepted (push=1) exactly in a cycle with rd_en_n=0 and sto_full=0. push_data equals rd_data, and push_last equals the inverse of rd_last_n.
- R8: The read lane starts at 0 and steps 0,1,2,3,0,... once per accepted word. Its value appears on push_lane and on phase_cnt during the read phase.
- R9: An accepted word with rd_last_n=0 ends the operation. From the next cycle op_ready=1 and phase_cnt=0.
- R10: rd_en_n is ignored outside the read phase: no push occurs there.
- R11: addr_en_n is ignored outside the address phase: phase_cnt and the state it reflects do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | New target operation offered by the bus side |
| op_ready | output | 1 | Block is idle and can take an operation |
| op_cmd | input | CW | Bus command of the offered operation |
| op_addr_lo | input | DW | First address word |
| op_addr_hi | input | DW | Second address word (dual-address only) |
| op_dual | input | 1 | Operation carries two address words |
| op_burst | input | 1 | Operation is a burst |
| tgt_req_n | output | 1 | Active-low request to the application |
| addr_en_n | input | 1 | Active-low address enable from the application |
| cmd_out | output | CW | Captured bus command |
| app_data | output | DW | Shared data bus toward the application |
| app_flags | output | 2 | Bit 1 burst, bit 0 dual-address |
| fifo_sel | output | 1 | 1 while address words are on app_data |
| addr_last_n | output | 1 | Active-low marker of the final address word |
| phase_cnt | output | 2 | Address word index or read lane |
| rd_data | input | DW | Read word from the application |
| rd_en_n | input | 1 | Active-low read-data enable |
| rd_last_n | input | 1 | Active-low marker of the final read word |
| rd_full_n | output | 1 | Active-low full indication to the application |
| sto_full | input | 1 | Read FIFO has no room |
| push | output | 1 | Write strobe into the read FIFO |
| push_data | output | DW | Word written into the read FIFO |
| push_lane | output | 2 | Lane of the written word |
| push_last | output | 1 | Written word is the final one |

## Verification
A stuck or skipped phase shows in the same cycle on tgt_req_n, fifo_sel and rd_full_n. These three outputs are decoded straight from the state. A wrong address word index shows at once on app_data and addr_last_n. A dual-address operation is the only case that exposes a lane or index off by one in the address phase. A lane counter that moves on refused words, or fails to wrap, shows on the next accepted push through push_lane. Random stalls from sto_full are needed to expose it.

// File: rtl/tgt_addr_handoff.sv
module tgt_addr_handoff #(
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [CW-1:0] op_cmd,
  input  logic [DW-1:0] op_addr_lo,
  input  logic [DW-1:0] op_addr_hi,
  input  logic          op_dual,
  input  logic          op_burst,
  output logic          tgt_req_n,
  input  logic          addr_en_n,
  output logic [CW-1:0] cmd_out,
  output logic [DW-1:0] app_data,
  output logic [1:0]    app_flags,
  output logic          fifo_sel,
  output logic          addr_last_n,
  output logic [((LANES > 2) ? $clog2(LANES) : 1)-1:0] phase_cnt,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_en_n,
  input  logic          rd_last_n,
  output logic          rd_full_n,
  input  logic          sto_full,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic [((LANES > 2) ? $clog2(LANES) : 1)-1:0] push_lane,
  output logic          push_last
);

  localparam int PW = (LANES > 2) ? $clog2(LANES) : 1;
  localparam logic [PW-1:0] LANE_TOP = PW'(LANES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t           st;
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] lo_q, hi_q;
  logic          dual_q, burst_q, wsel_q;
  logic [PW-1:0] lane_q;

  wire in_idle    = (st == S_IDLE);
  wire in_addr    = (st == S_ADDR);
  wire in_data    = (st == S_DATA);
  wire op_take    = in_idle & op_valid;
  wire word_take  = in_addr & ~addr_en_n;
  wire final_word = (wsel_q == dual_q);
  wire rd_take    = in_data & ~rd_en_n & ~sto_full;

  assign op_ready    = in_idle;
  assign tgt_req_n   = ~in_addr;
  assign fifo_sel    = in_addr;
  assign cmd_out     = cmd_q;
  assign app_flags   = in_addr ? {burst_q, dual_q} : 2'b00;
  assign app_data    = in_addr ? (wsel_q ? hi_q : lo_q) : '0;
  assign addr_last_n = ~(in_addr & final_word);
  assign phase_cnt   = in_addr ? PW'(wsel_q) : (in_data ? lane_q : '0);
  assign rd_full_n   = in_data & ~sto_full;
  assign push        = rd_take;
  assign push_data   = rd_data;
  assign push_lane   = lane_q;
  assign push_last   = ~rd_last_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      dual_q  <= 1'b0;
      burst_q <= 1'b0;
      wsel_q  <= 1'b0;
      lane_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (op_take) begin
          st      <= S_ADDR;
          cmd_q   <= op_cmd;
          lo_q    <= op_addr_lo;
          hi_q    <= op_addr_hi;
          dual_q  <= op_dual;
          burst_q <= op_burst;
          wsel_q  <= 1'b0;
        end
        S_ADDR: if (word_take) begin
          if (final_word) begin
            st     <= S_DATA;
            lane_q <= '0;
          end else begin
            wsel_q <= 1'b1;
          end
        end
        S_DATA: if (rd_take) begin
          if (!rd_last_n) begin
            st     <= S_IDLE;
            lane_q <= '0;
          end else begin
            lane_q <= (lane_q == LANE_TOP) ? '0 : lane_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  op_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (!tgt_req_n && !op_ready));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_req_n && addr_en_n) |=> $stable(app_data) && $stable(phase_cnt));

  // R5
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_last_n) |-> (!tgt_req_n && phase_cnt == PW'(app_flags[0])));

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_req_n && !addr_en_n && !addr_last_n) |=> (tgt_req_n && !op_ready));

  // R8
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_last) |=>
      (phase_cnt == (($past(phase_cnt) == LANE_TOP) ? '0 : $past(phase_cnt) + 1'b1)));

  // R9
  op_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_last) |=> (op_ready && phase_cnt == '0));

  // R10
  no_stray_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_full_n) |-> !push);

endmodule

// File: tb/test_tgt_addr_handoff.sv
module test_tgt_addr_handoff;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_dual = 1'b0, op_burst = 1'b0;
  logic [CW-1:0] op_cmd = '0;
  logic [DW-1:0] op_addr_lo = '0, op_addr_hi = '0, rd_data = '0;
  logic addr_en_n = 1'b1, rd_en_n = 1'b1, rd_last_n = 1'b1, sto_full = 1'b0;
  logic op_ready, tgt_req_n, fifo_sel, addr_last_n, rd_full_n, push, push_last;
  logic [CW-1:0] cmd_out;
  logic [DW-1:0] app_data, push_data;
  logic [1:0] app_flags, phase_cnt, push_lane;

  int tests = 0, fails = 0;
  int md = 0, wc = 0, ln = 0, m_dual = 0, m_burst = 0;
  logic [CW-1:0] m_cmd = '0;
  logic [DW-1:0] m_lo = '0, m_hi = '0;
  bit done = 0;

  tgt_addr_handoff i_tgt_addr_handoff (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_cmd(op_cmd), .op_addr_lo(op_addr_lo), .op_addr_hi(op_addr_hi),
    .op_dual(op_dual), .op_burst(op_burst), .tgt_req_n(tgt_req_n),
    .addr_en_n(addr_en_n), .cmd_out(cmd_out), .app_data(app_data),
    .app_flags(app_flags), .fifo_sel(fifo_sel), .addr_last_n(addr_last_n),
    .phase_cnt(phase_cnt), .rd_data(rd_data), .rd_en_n(rd_en_n),
    .rd_last_n(rd_last_n), .rd_full_n(rd_full_n), .sto_full(sto_full),
    .push(push), .push_data(push_data), .push_lane(push_lane),
    .push_last(push_last)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = 0; wc = 0; ln = 0; m_dual = 0; m_burst = 0;
      m_cmd = '0; m_lo = '0; m_hi = '0;
    end else if (md == 0) begin
      if (op_valid) begin
        md = 1; wc = 0; m_cmd = op_cmd; m_lo = op_addr_lo; m_hi = op_addr_hi;
        m_dual = int'(op_dual); m_burst = int'(op_burst);
      end
    end else if (md == 1) begin
      if (!addr_en_n) begin
        if (wc == m_dual) begin md = 2; ln = 0; end
        else wc = 1;
      end
    end else begin
      if (!rd_en_n && !sto_full) begin
        if (!rd_last_n) begin md = 0; ln = 0; end
        else ln = (ln + 1) % 4;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      automatic string t1 = rst_n ? "" : "R1";
      automatic logic  e_push = (md == 2) && !rd_en_n && !sto_full;
      automatic int    e_pc = (md == 1) ? wc : ((md == 2) ? ln : 0);
      chk(rst_n ? "R6" : t1, "tgt_req_n", 64'(tgt_req_n), 64'(md != 1));
      chk(rst_n ? ((md == 0) ? "R2" : "R9") : t1, "op_ready", 64'(op_ready), 64'(md == 0));
      chk(rst_n ? "R3" : t1, "fifo_sel", 64'(fifo_sel), 64'(md == 1));
      chk(rst_n ? "R3" : t1, "cmd_out", 64'(cmd_out), 64'(m_cmd));
      chk(rst_n ? "R3" : t1, "app_flags", 64'(app_flags),
          64'((md == 1) ? (m_burst * 2 + m_dual) : 0));
      chk(rst_n ? "R4" : t1, "app_data", 64'(app_data),
          64'((md == 1) ? ((wc == 1) ? m_hi : m_lo) : '0));
      chk(rst_n ? "R5" : t1, "addr_last_n", 64'(addr_last_n), 64'(!(md == 1 && wc == m_dual)));
      chk(rst_n ? ((md != 1 && !addr_en_n) ? "R11" : "R8") : t1, "phase_cnt",
          64'(phase_cnt), 64'(e_pc));
      chk(rst_n ? "R6" : t1, "rd_full_n", 64'(rd_full_n), 64'(md == 2 && !sto_full));
      chk(rst_n ? ((md != 2) ? "R10" : "R7") : t1, "push", 64'(push), 64'(e_push));
      if (e_push) begin
        chk("R7", "push_data", 64'(push_data), 64'(rd_data));
        chk("R7", "push_last", 64'(push_last), 64'(!rd_last_n));
        chk("R8", "push_lane", 64'(push_lane), 64'(ln));
      end
    end
  end

  task automatic drive_random();
    op_valid   = ($urandom % 2) == 0;
    op_cmd     = CW'($urandom);
    op_addr_lo = $urandom;
    op_addr_hi = $urandom;
    op_dual    = ($urandom % 2) == 0;
    op_burst   = ($urandom % 2) == 0;
    addr_en_n  = ($urandom % 2) == 0;
    rd_en_n    = ($urandom % 5) < 2;
    rd_last_n  = ($urandom % 7) != 0;
    sto_full   = ($urandom % 4) == 0;
    rd_data    = $urandom;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #2;
      if (i == 2000) rst_n = 1'b0;
      if (i == 2002) rst_n = 1'b1;
      drive_random();
    end
    @(posedge clk);
    #5 done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule